// File: doc/BRIEF.md
# Row Scan Shift Register with Drive-Level Select

This block is the row-scanning half of a display driver. A chain of row stages, 240 by default, moves a scan token one place each time the line pulse falls. The token enters from one of two cascade pins and leaves on the other, so several such blocks can be chained. A direction input picks the travel direction and, with it, which cascade pin is the input and which one is driven.

Each stage also produces a 2-bit drive-level code. The code depends on whether the row holds the token, on the frame polarity and on an active-low display-off input. A later level shifter turns each code into one of four voltages. The codes are registered, so they always match the current contents of the shift stages.

Both cascade pins are given as an input, an output value and an output enable. This lets a pad ring build the bidirectional pins outside the block.

Top module: `row_scan_shifter`

## Requirements
- R1: While `rst` is high, every stage is cleared and every level code is 00. The direction register is cleared to forward, so `casc_b_oe`=1, `casc_a_oe`=0 and `casc_b_out`=0.
- R2: The stages change only at the clock edge where `line_pulse` is sampled low after being sampled high on the previous edge. A rising line pulse, or a line pulse held steady at either level, leaves every stage unchanged.
- R3: Forward (`dir_rev`=0): on a falling line pulse, stage 0 loads `casc_a_in` and stage i loads stage i-1.
- R4: Reverse (`dir_rev`=1): on a falling line pulse, the last stage loads `casc_b_in` and stage i loads stage i+1.
- R5: `dir_rev` is registered before use. In forward mode `casc_b_oe`=1, `casc_b_out` equals the last stage, and `casc_a_oe`=0. In reverse mode `casc_a_oe`=1, `casc_a_out` equals stage 0, and `casc_b_oe`=0. A token shifted in therefore appears on the driven pin after as many falling pulses as there are stages.
- R6: When `disp_on_n` is low, every level code is 00, whatever the stages hold.
- R7: With the display on, a stage that holds 1 gets code 11 when `frame_pol` is 1 and code 00 when it is 0.
- R8: With the display on, a stage that holds 0 gets code 01 when `frame_pol` is 1 and code 10 when it is 0.
- R9: Stage i's code sits at `lvl_o[2i+1:2i]`. It is registered on the same edge as the stage, so after every edge it reflects the new stage value and the `frame_pol` and `disp_on_n` sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_pulse | input | 1 | Line pulse; its falling edge advances the scan |
| dir_rev | input | 1 | 0 = forward (A to B), 1 = reverse (B to A) |
| frame_pol | input | 1 | Frame polarity |
| disp_on_n | input | 1 | Active-low display-off; low forces ground code |
| casc_a_in | input | 1 | Cascade pin A input value |
| casc_a_out | output | 1 | Cascade pin A drive value |
| casc_a_oe | output | 1 | Cascade pin A output enable |
| casc_b_in | input | 1 | Cascade pin B input value |
| casc_b_out | output | 1 | Cascade pin B drive value |
| casc_b_oe | output | 1 | Cascade pin B output enable |
| lvl_o | output | 2*NUM_ROWS | Packed 2-bit level codes, stage i at bits 2i+1:2i |

## Verification
The hardest case to reach from the ports is a token reaching the far end of the chain and appearing on the driven cascade pin. This takes one full line pulse per stage, in each direction. The bench uses an 8-stage chain, injects a single token and clocks exactly that many line pulses, then checks the pin. In between it feeds bit patterns from a shift-register generator under all four polarity/display-off combinations, and checks every stage's code after every line.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;
  typedef enum logic [1:0] {
    LVL_GND   = 2'b00,
    LVL_LOMID = 2'b01,
    LVL_HIMID = 2'b10,
    LVL_TOP   = 2'b11
  } drv_lvl_e;

  function automatic logic [1:0] pick_level(input logic sel, input logic pol,
                                            input logic on_n);
    drv_lvl_e l;
    if (!on_n)     l = LVL_GND;
    else if (sel)  l = pol ? LVL_TOP : LVL_GND;
    else           l = pol ? LVL_LOMID : LVL_HIMID;
    return l;
  endfunction
endpackage

// File: rtl/row_scan_ctrl.sv
module row_scan_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic lp_i,
  input  logic dir_i,
  output logic fall_o,
  output logic rev_q_o
);
  logic lp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lp_q    <= 1'b0;
      rev_q_o <= 1'b0;
    end else begin
      lp_q    <= lp_i;
      rev_q_o <= dir_i;
    end
  end

  assign fall_o = lp_q & ~lp_i;
endmodule

// File: rtl/row_scan_chain.sv
module row_scan_chain #(
  parameter int NUM_ROWS = 240
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fall_i,
  input  logic                rev_i,
  input  logic                a_in,
  input  logic                b_in,
  output logic [NUM_ROWS-1:0] rows_d,
  output logic [NUM_ROWS-1:0] rows_q
);
  localparam int LAST = NUM_ROWS - 1;

  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_stage
    logic from_lo, from_hi;
    if (g == 0) begin : g_first
      assign from_lo = a_in;
    end else begin : g_mid_lo
      assign from_lo = rows_q[g-1];
    end
    if (g == LAST) begin : g_last
      assign from_hi = b_in;
    end else begin : g_mid_hi
      assign from_hi = rows_q[g+1];
    end
    always_comb begin
      if (fall_i) rows_d[g] = rev_i ? from_hi : from_lo;
      else        rows_d[g] = rows_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rows_q <= '0;
    else     rows_q <= rows_d;
  end

  // R2
  hold_rows_chk: assert property (@(posedge clk) disable iff (rst)
    !fall_i |=> $stable(rows_q));
  // R3
  fwd_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_i && !rev_i) |=> rows_q[0] == $past(a_in));
  // R4
  rev_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (fall_i && rev_i) |=> rows_q[LAST] == $past(b_in));
endmodule

// File: rtl/row_level_enc.sv
module row_level_enc
  import row_scan_pkg::*;
#(
  parameter int NUM_ROWS = 240
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_ROWS-1:0]   rows_d,
  input  logic                  pol_i,
  input  logic                  on_n_i,
  output logic [2*NUM_ROWS-1:0] lvl_q
);
  for (genvar g = 0; g < NUM_ROWS; g++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst) lvl_q[2*g+1:2*g] <= LVL_GND;
      else     lvl_q[2*g+1:2*g] <= pick_level(rows_d[g], pol_i, on_n_i);
    end
  end

  // R6
  off_gnd_chk: assert property (@(posedge clk) disable iff (rst)
    !on_n_i |=> lvl_q == '0);
  // R7
  sel_top_chk: assert property (@(posedge clk) disable iff (rst)
    (on_n_i && pol_i && rows_d[0]) |=> lvl_q[1:0] == 2'b11);
  // R8
  idle_mid_chk: assert property (@(posedge clk) disable iff (rst)
    (on_n_i && !pol_i && !rows_d[0]) |=> lvl_q[1:0] == 2'b10);
endmodule

// File: rtl/row_scan_shifter.sv
module row_scan_shifter #(
  parameter int NUM_ROWS = 240
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  line_pulse,
  input  logic                  dir_rev,
  input  logic                  frame_pol,
  input  logic                  disp_on_n,
  input  logic                  casc_a_in,
  output logic                  casc_a_out,
  output logic                  casc_a_oe,
  input  logic                  casc_b_in,
  output logic                  casc_b_out,
  output logic                  casc_b_oe,
  output logic [2*NUM_ROWS-1:0] lvl_o
);
  localparam int LAST = NUM_ROWS - 1;

  logic                fall;
  logic                rev_q;
  logic [NUM_ROWS-1:0] rows_d;
  logic [NUM_ROWS-1:0] rows_q;

  row_scan_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .lp_i   (line_pulse),
    .dir_i  (dir_rev),
    .fall_o (fall),
    .rev_q_o(rev_q)
  );

  row_scan_chain #(.NUM_ROWS(NUM_ROWS)) chain_i (
    .clk   (clk),
    .rst   (rst),
    .fall_i(fall),
    .rev_i (rev_q),
    .a_in  (casc_a_in),
    .b_in  (casc_b_in),
    .rows_d(rows_d),
    .rows_q(rows_q)
  );

  row_level_enc #(.NUM_ROWS(NUM_ROWS)) enc_i (
    .clk   (clk),
    .rst   (rst),
    .rows_d(rows_d),
    .pol_i (frame_pol),
    .on_n_i(disp_on_n),
    .lvl_q (lvl_o)
  );

  assign casc_a_oe  = rev_q;
  assign casc_b_oe  = ~rev_q;
  assign casc_a_out = rows_q[0];
  assign casc_b_out = rows_q[LAST];

  // R5
  dir_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> casc_a_oe == $past(dir_rev));
endmodule

// File: tb/row_scan_shifter_tb_top.sv
`timescale 1ns/1ps
module row_scan_shifter_tb_top;
  localparam int N = 8;

  logic clk = 0, rst = 1, lp = 0, dir = 0, fp = 0, don = 1, a_in = 0, b_in = 0;
  logic a_out, a_oe, b_out, b_oe;
  logic [2*N-1:0] lvl;
  logic [N-1:0] m;
  logic [7:0] lfsr = 8'hA5;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  row_scan_shifter #(.NUM_ROWS(N)) dut_i (
    .clk(clk), .rst(rst), .line_pulse(lp), .dir_rev(dir), .frame_pol(fp),
    .disp_on_n(don), .casc_a_in(a_in), .casc_a_out(a_out), .casc_a_oe(a_oe),
    .casc_b_in(b_in), .casc_b_out(b_out), .casc_b_oe(b_oe), .lvl_o(lvl));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lvl(input logic s);
    if (!don) return 0;
    if (s) return fp ? 3 : 0;
    return fp ? 1 : 2;
  endfunction

  task automatic check_all(input string tag);
    for (int i = 0; i < N; i++) begin
      string r;
      r = !don ? "R6" : (m[i] ? "R7" : "R8");
      chk({r, "/R9 ", tag}, int'(lvl[2*i +: 2]), exp_lvl(m[i]));
    end
    if (!dir) begin
      chk({"R5 b_oe ", tag}, int'(b_oe), 1);
      chk({"R5 a_oe ", tag}, int'(a_oe), 0);
      chk({"R5 b_out ", tag}, int'(b_out), int'(m[N-1]));
    end else begin
      chk({"R5 a_oe ", tag}, int'(a_oe), 1);
      chk({"R5 b_oe ", tag}, int'(b_oe), 0);
      chk({"R5 a_out ", tag}, int'(a_out), int'(m[0]));
    end
  endtask

  task automatic line(input logic bit_in, input string tag);
    lp = 1;
    tick();
    lp = 0;
    if (!dir) a_in = bit_in; else b_in = bit_in;
    if (!dir) begin a_in = bit_in; b_in = ~bit_in; end
    else      begin b_in = bit_in; a_in = ~bit_in; end
    tick();
    if (!dir) m = {m[N-2:0], bit_in};
    else      m = {bit_in, m[N-1:1]};
    check_all(tag);
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    return lfsr[0];
  endfunction

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m = '0;
    @(negedge clk);
    tick(); tick();
    // R1 reset state
    chk("R1 lvl", int'(lvl), 0);
    chk("R1 b_oe", int'(b_oe), 1);
    chk("R1 a_oe", int'(a_oe), 0);
    chk("R1 b_out", int'(b_out), 0);
    rst = 0;
    tick();
    check_all("after reset");

    // R3 forward sweeps under all polarity/display combinations
    for (int c = 0; c < 4; c++) begin
      fp = c[0]; don = c[1];
      for (int k = 0; k < N + 2; k++) line(next_bit(), "R3 fwd");
    end
    fp = 1; don = 1;

    // R2 rising edge and steady level do not shift
    a_in = ~m[0]; lp = 1;
    tick();
    check_all("R2 rising");
    lp = 0; a_in = 1;
    tick();
    m = {m[N-2:0], 1'b1};
    check_all("R2 fall");
    for (int k = 0; k < 3; k++) begin
      a_in = ~a_in;
      tick();
      check_all("R2 held low");
    end

    // R3/R5 single token exits on pin B after N lines
    for (int k = 0; k < N; k++) line(1'b0, "R3 clear");
    line(1'b1, "R3 token");
    for (int k = 0; k < N - 1; k++) line(1'b0, "R3 travel");
    chk("R3 token at B", int'(b_out), 1);

    // R4 reverse direction
    dir = 1;
    tick();
    check_all("R5 dir switch");
    for (int c = 0; c < 4; c++) begin
      fp = c[1]; don = c[0];
      for (int k = 0; k < N + 2; k++) line(next_bit(), "R4 rev");
    end
    fp = 0; don = 1;
    for (int k = 0; k < N; k++) line(1'b0, "R4 clear");
    line(1'b1, "R4 token");
    for (int k = 0; k < N - 1; k++) line(1'b0, "R4 travel");
    chk("R4 token at A", int'(a_out), 1);

    // R6 display off overrides a full register
    for (int k = 0; k < N; k++) line(1'b1, "R4 fill");
    don = 0;
    tick();
    check_all("R6 off");
    don = 1;
    tick();
    check_all("R7 on again");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule